// File: doc/BRIEF.md
# Byte-Enable Bus Cycle Splitter

This block connects a core-side load/store port to a 32-bit external memory bus on which the address carries only a word index. Byte selection comes from four active-low byte-enable lines. A request gives a byte address, an operand size of one, two or four bytes, a direction, write data, and two qualifiers: memory versus I/O, and data versus code. The block turns each request into one non-pipelined bus cycle. When the operand spills past a 4-byte boundary, it issues two cycles instead.

Each bus cycle opens with a one-clock start strobe, during which the cycle-type outputs are valid. The cycle then waits for an active-low ready. Read data from the cycles is shifted and merged so that the operand appears right-aligned on the core side. Write data is steered onto the byte lanes that match the enables. A two-bit low-address output is derived from the enables for buses that need it. A lock output can be held across several requests, so that a read-modify-write sequence runs without interruption.

Top module: `bus_split_unit`

## Requirements
- R1: The bus address is the byte address shifted right by two. An operand that stays inside one 4-byte word takes exactly one bus cycle.
- R2: `bus_be_n[i]` is active low and qualifies data bits 8i+7:8i. `req_size` is encoded as 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. The enabled lanes are the operand's bytes within the addressed word. All enables are high outside a bus cycle.
- R3: An operand crossing a 4-byte boundary takes two cycles. The lower word goes first. The second cycle uses word address plus one, with enables for the remaining bytes.
- R4: `bus_ads_n` is low for exactly one clock at the start of each cycle. In that clock, `bus_wr` (1 = write), `bus_mio` (1 = memory) and `bus_dc` (1 = data) are valid, and they are held until the cycle ends.
- R5: A cycle ends at a clock edge where `bus_rdy_n` is sampled low, from the second clock of the cycle on. While `bus_rdy_n` is high, wait clocks are added.
- R6: The read result has operand byte 0 at bits 7:0. Result bytes beyond the operand size are zero.
- R7: Write data byte k is driven on the lane of byte address addr+k in the cycle that covers that address.
- R8: `bus_a10` equals the index of the lowest active byte enable: 0 for lane 0, 1 for lane 1, 2 for lane 2, 3 for lane 3.
- R9: `bus_lock` is high from the start strobe of a request accepted with `req_lock` high. It stays high across idle clocks and further requests while `req_lock` stays high. It goes low in the clock after a request's final ready at which `req_lock` is low.
- R10: `req_done` is a one-clock pulse in the clock after the final ready, and it carries `req_rdata`. `req_busy` is high from acceptance until that clock. A `req_valid` seen while busy is ignored.
- R11: After reset, `bus_ads_n` is high, `bus_lock` is low, `req_busy` is low and `req_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when not busy |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 2 | Operand size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_data | input | 1 | 1 = data access, 0 = code fetch |
| req_lock | input | 1 | Level request to hold the bus lock |
| req_wdata | input | 32 | Store data, right-aligned |
| req_busy | output | 1 | Request in progress |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Load result, right-aligned |
| bus_addr | output | 30 | Word address |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_a10 | output | 2 | Low address bits derived from enables |
| bus_ads_n | output | 1 | Active-low cycle-start strobe |
| bus_wr | output | 1 | 1 = write cycle |
| bus_mio | output | 1 | 1 = memory cycle |
| bus_dc | output | 1 | 1 = data cycle |
| bus_lock | output | 1 | Bus lock |
| bus_wdata | output | 32 | Write data on byte lanes |
| bus_rdata | input | 32 | Read data from the bus |
| bus_rdy_n | input | 1 | Active-low cycle ready |

## Verification
The bench targets operands that straddle a word boundary by one, two and three bytes, in both directions. A design that got the split wrong would issue one cycle with wrapped enables, repeat the same word address, or merge the two read words in the wrong order, which garbles the result bytes. Halfwords and bytes at odd lanes check the enable pattern, the derived low address bits and the lane steering of stores. A wrong shift would write bytes into neighbouring lanes of the bus-side memory model. The lock sequence and the requests issued while busy catch a lock released between the read and the write of an exchange, and a second request slipping in mid-cycle.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2
  } bsu_state_t;
endpackage

// File: rtl/bsu_lane_plan.sv
module bsu_lane_plan #(
  parameter int LANES  = 4,
  parameter int SIZE_W = 2,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW    = 8 * LANES
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  input  logic [DW-1:0]     wdata,
  output logic [LANES-1:0]  en_lo,
  output logic [LANES-1:0]  en_hi,
  output logic              split,
  output logic [DW-1:0]     wd_lo,
  output logic [DW-1:0]     wd_hi
);
  logic [2*LANES-1:0] span;
  logic [2*DW-1:0]    wide;
  int                 nb;

  always_comb begin
    if (int'(size) >= OFF_W) nb = LANES;
    else                     nb = 1 << size;
  end

  for (genvar i = 0; i < 2*LANES; i++) begin : g_span
    assign span[i] = (i >= int'(off)) && (i < int'(off) + nb);
  end

  always_comb begin
    wide  = {{DW{1'b0}}, wdata} << {off, 3'b000};
    wd_lo = wide[DW-1:0];
    wd_hi = wide[2*DW-1:DW];
  end

  assign en_lo = span[LANES-1:0];
  assign en_hi = span[2*LANES-1:LANES];
  assign split = |en_hi;
endmodule

// File: rtl/bsu_read_merge.sv
module bsu_read_merge #(
  parameter int LANES  = 4,
  parameter int SIZE_W = 2,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW    = 8 * LANES
) (
  input  logic [DW-1:0]     lo_word,
  input  logic [DW-1:0]     hi_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  output logic [DW-1:0]     result
);
  logic [2*DW-1:0] shifted;
  int              nb;

  always_comb begin
    if (int'(size) >= OFF_W) nb = LANES;
    else                     nb = 1 << size;
    shifted = {hi_word, lo_word} >> {off, 3'b000};
  end

  for (genvar b = 0; b < LANES; b++) begin : g_keep
    assign result[8*b +: 8] = (b < nb) ? shifted[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/bsu_low_addr.sv
module bsu_low_addr #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] en,
  output logic [OFF_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (en[i]) idx = OFF_W'(i);
    end
  end
endmodule

// File: rtl/bus_split_unit.sv
module bus_split_unit #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW    = 8 * LANES,
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_data,
  input  logic              req_lock,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_busy,
  output logic              req_done,
  output logic [DW-1:0]     req_rdata,
  output logic [WA_W-1:0]   bus_addr,
  output logic [LANES-1:0]  bus_be_n,
  output logic [OFF_W-1:0]  bus_a10,
  output logic              bus_ads_n,
  output logic              bus_wr,
  output logic              bus_mio,
  output logic              bus_dc,
  output logic              bus_lock,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_rdy_n
);
  import bsu_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  // lane planning of the incoming request
  logic [LANES-1:0] pl_en_lo, pl_en_hi;
  logic             pl_split;
  logic [DW-1:0]    pl_wd_lo, pl_wd_hi;

  bsu_lane_plan #(.LANES(LANES), .SIZE_W(SIZE_W)) u_plan (
    .off   (req_addr[OFF_W-1:0]),
    .size  (req_size),
    .wdata (req_wdata),
    .en_lo (pl_en_lo),
    .en_hi (pl_en_hi),
    .split (pl_split),
    .wd_lo (pl_wd_lo),
    .wd_hi (pl_wd_hi)
  );

  // state
  bsu_state_t       st_q, st_d;
  logic             phase_q, phase_d;
  logic             lock_q, lock_d;
  logic             done_q;
  logic [WA_W-1:0]  word_q;
  logic [OFF_W-1:0] off_q;
  logic [SIZE_W-1:0] size_q;
  logic             split_q, wr_q, mio_q, dc_q;
  logic [LANES-1:0] en_lo_q, en_hi_q;
  logic [DW-1:0]    wd_lo_q, wd_hi_q, buf_lo_q, rdata_q;

  logic accept, rdy, last, ld_req, ld_lo, ld_done;
  logic [DW-1:0] merged, mrg_lo, mrg_hi;
  logic [LANES-1:0] en_act;

  assign accept  = (st_q == ST_IDLE) && req_valid;
  assign rdy     = (st_q == ST_WAIT) && !bus_rdy_n;
  assign last    = phase_q || !split_q;
  assign ld_req  = accept;
  assign ld_lo   = rdy && !last;
  assign ld_done = rdy && last;

  // next state
  always_comb begin
    st_d    = st_q;
    phase_d = phase_q;
    lock_d  = lock_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_ADDR;
          phase_d = 1'b0;
          lock_d  = lock_q | req_lock;
        end else begin
          lock_d  = lock_q & req_lock;
        end
      end
      ST_ADDR: st_d = ST_WAIT;
      ST_WAIT: begin
        if (rdy) begin
          if (last) begin
            st_d   = ST_IDLE;
            lock_d = lock_q & req_lock;
          end else begin
            st_d    = ST_ADDR;
            phase_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
      lock_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      phase_q <= phase_d;
      lock_q  <= lock_d;
      done_q  <= ld_done;
    end
  end

  // request registers, loaded on acceptance
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      word_q  <= '0;
      off_q   <= '0;
      size_q  <= '0;
      split_q <= 1'b0;
      wr_q    <= 1'b0;
      mio_q   <= 1'b0;
      dc_q    <= 1'b0;
      en_lo_q <= '0;
      en_hi_q <= '0;
      wd_lo_q <= '0;
      wd_hi_q <= '0;
    end else if (ld_req) begin
      word_q  <= req_addr[ADDR_W-1:OFF_W];
      off_q   <= req_addr[OFF_W-1:0];
      size_q  <= req_size;
      split_q <= pl_split;
      wr_q    <= req_write;
      mio_q   <= req_mem;
      dc_q    <= req_data;
      en_lo_q <= pl_en_lo;
      en_hi_q <= pl_en_hi;
      wd_lo_q <= pl_wd_lo;
      wd_hi_q <= pl_wd_hi;
    end
  end

  // read data capture
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     buf_lo_q <= '0;
    else if (ld_lo) buf_lo_q <= bus_rdata;
  end

  assign mrg_lo = split_q ? buf_lo_q  : bus_rdata;
  assign mrg_hi = split_q ? bus_rdata : '0;

  bsu_read_merge #(.LANES(LANES), .SIZE_W(SIZE_W)) u_merge (
    .lo_word (mrg_lo),
    .hi_word (mrg_hi),
    .off     (off_q),
    .size    (size_q),
    .result  (merged)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       rdata_q <= '0;
    else if (ld_done) rdata_q <= merged;
  end

  // bus side
  assign en_act = (st_q == ST_IDLE) ? '0 : (phase_q ? en_hi_q : en_lo_q);

  bsu_low_addr #(.LANES(LANES)) u_low (
    .en  (en_act),
    .idx (bus_a10)
  );

  assign bus_addr  = word_q + WA_W'(phase_q);
  assign bus_be_n  = ~en_act;
  assign bus_ads_n = (st_q != ST_ADDR);
  assign bus_wr    = wr_q;
  assign bus_mio   = mio_q;
  assign bus_dc    = dc_q;
  assign bus_lock  = lock_q;
  assign bus_wdata = phase_q ? wd_hi_q : wd_lo_q;
  assign req_busy  = (st_q != ST_IDLE);
  assign req_done  = done_q;
  assign req_rdata = rdata_q;

  // assertions
  a_r4_ads_one_clock: assert property (@(posedge clk) disable iff (!rst_s)
    !bus_ads_n |=> bus_ads_n);
  a_r4_type_held: assert property (@(posedge clk) disable iff (!rst_s)
    !bus_ads_n |=> ($stable(bus_wr) && $stable(bus_mio) && $stable(bus_dc)
                    && $stable(bus_addr) && $stable(bus_be_n)));
  a_r2_some_enable: assert property (@(posedge clk) disable iff (!rst_s)
    !bus_ads_n |-> ($countones(~bus_be_n) != 0));
  a_r3_next_word: assert property (@(posedge clk) disable iff (!rst_s)
    (!bus_ads_n && phase_q) |-> (bus_addr == $past(bus_addr) + WA_W'(1)));
  a_r8_lane0_low: assert property (@(posedge clk) disable iff (!rst_s)
    (!bus_ads_n && !bus_be_n[0]) |-> (bus_a10 == '0));
  a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_lock && req_busy && !(rdy && last)) |=> bus_lock);
  a_r9_lock_drop: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_lock && rdy && last && !req_lock) |=> !bus_lock);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    req_done |=> !req_done);
endmodule

// File: tb/tb_bus_split_unit.sv
module tb_bus_split_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_mem, req_data, req_lock;
  logic [31:0] req_addr, req_wdata, req_rdata;
  logic [1:0]  req_size;
  logic        req_busy, req_done;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be_n;
  logic [1:0]  bus_a10;
  logic        bus_ads_n, bus_wr, bus_mio, bus_dc, bus_lock;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rdy_n;

  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  bus_split_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_mem(req_mem),
    .req_data(req_data), .req_lock(req_lock), .req_wdata(req_wdata),
    .req_busy(req_busy), .req_done(req_done), .req_rdata(req_rdata),
    .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_a10(bus_a10),
    .bus_ads_n(bus_ads_n), .bus_wr(bus_wr), .bus_mio(bus_mio), .bus_dc(bus_dc),
    .bus_lock(bus_lock), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy_n(bus_rdy_n)
  );

  // memory model: byte at address a starts as 8'h40 + a
  logic [31:0] mem [16];
  int          waits = 0;
  int          wcnt = 0;
  logic        in_cyc = 1'b0;
  int          ncyc = 0;
  logic [29:0] lg_addr [4];
  logic [3:0]  lg_be   [4];
  logic [1:0]  lg_a10  [4];
  logic        lg_wr [4], lg_mio [4], lg_dc [4], lg_lock [4];
  logic [31:0] lg_wd [4];

  always @(negedge clk) begin
    if (rst_n && !bus_ads_n) begin
      if (ncyc < 4) begin
        lg_addr[ncyc] = bus_addr;  lg_be[ncyc] = bus_be_n;
        lg_a10[ncyc]  = bus_a10;   lg_wr[ncyc] = bus_wr;
        lg_mio[ncyc]  = bus_mio;   lg_dc[ncyc] = bus_dc;
        lg_lock[ncyc] = bus_lock;  lg_wd[ncyc] = bus_wdata;
      end
      ncyc++;
      wcnt = waits;
      in_cyc = 1'b1;
      bus_rdy_n <= 1'b1;
    end else if (in_cyc) begin
      if (wcnt == 0) begin
        bus_rdy_n <= 1'b0;
        bus_rdata <= mem[bus_addr[3:0]];
        if (bus_wr)
          for (int b = 0; b < 4; b++)
            if (!bus_be_n[b]) mem[bus_addr[3:0]][8*b +: 8] = bus_wdata[8*b +: 8];
        in_cyc = 1'b0;
      end else begin
        wcnt--;
      end
    end else begin
      bus_rdy_n <= 1'b1;
    end
  end

  function automatic logic [7:0] mbyte(input int a);
    return mem[(a >> 2) & 15][8*(a & 3) +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] got;

  task automatic do_req(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input logic mio, input logic dc,
                        input logic lk, input logic drop_lk);
    int lim;
    @(negedge clk);
    ncyc = 0;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = wd; req_mem = mio; req_data = dc; req_lock = lk;
    @(negedge clk);
    req_valid = 1'b0;
    if (drop_lk) req_lock = 1'b0;
    lim = 0;
    while (!req_done && lim < 200) begin
      @(negedge clk);
      lim++;
    end
    got = req_rdata;
    chk(req_done && !req_busy, "R10 done with busy low", {30'b0, req_done, req_busy}, 32'h2);
  endtask

  task automatic t_reset;
    chk(bus_ads_n === 1'b1, "R11 ads idle", {31'b0, bus_ads_n}, 32'h1);
    chk(bus_lock === 1'b0, "R11 lock low", {31'b0, bus_lock}, 32'h0);
    chk(req_busy === 1'b0 && req_done === 1'b0, "R11 busy/done low",
        {30'b0, req_busy, req_done}, 32'h0);
    chk(bus_be_n === 4'hF, "R2 enables idle high", {28'b0, bus_be_n}, 32'hF);
  endtask

  task automatic t_aligned_read;
    do_req(32'h10, 2'd2, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(ncyc == 1 && lg_addr[0] == 30'h4, "R1 one cycle word 4", {lg_addr[0][27:0], ncyc[3:0]}, 32'h41);
    chk(lg_be[0] == 4'h0 && lg_a10[0] == 2'd0, "R2 R8 full word", {26'b0, lg_a10[0], lg_be[0]}, 32'h0);
    chk(lg_wr[0] == 1'b0 && lg_mio[0] && lg_dc[0], "R4 read/mem/data types",
        {29'b0, lg_wr[0], lg_mio[0], lg_dc[0]}, 32'h3);
    chk(got == 32'h53525150, "R6 aligned dword", got, 32'h53525150);
    @(negedge clk);
    chk(req_done == 1'b0, "R10 done one clock", {31'b0, req_done}, 32'h0);
  endtask

  task automatic t_byte_write;
    do_req(32'h23, 2'd0, 1'b1, 32'h000000A5, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(ncyc == 1 && lg_be[0] == 4'h7, "R2 byte lane 3", {28'b0, lg_be[0]}, 32'h7);
    chk(lg_a10[0] == 2'd3, "R8 lowest lane 3", {30'b0, lg_a10[0]}, 32'h3);
    chk(lg_wd[0][31:24] == 8'hA5, "R7 byte on lane 3", lg_wd[0], 32'hA5000000);
    chk(lg_wr[0] && !lg_mio[0] && !lg_dc[0], "R4 write/io/code types",
        {29'b0, lg_wr[0], lg_mio[0], lg_dc[0]}, 32'h4);
    chk(mem[8] == 32'hA5626160, "R7 memory word 8", mem[8], 32'hA5626160);
  endtask

  task automatic t_half_mid;
    do_req(32'h5, 2'd1, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(ncyc == 1 && lg_be[0] == 4'h9 && lg_a10[0] == 2'd1, "R2 R8 half lanes 1-2",
        {26'b0, lg_a10[0], lg_be[0]}, 32'h19);
    chk(got == 32'h00004645, "R6 half zero-extended", got, 32'h00004645);
  endtask

  task automatic t_split_dword;
    do_req(32'h6, 2'd2, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(ncyc == 2, "R3 two cycles", ncyc, 2);
    chk(lg_addr[0] == 30'h1 && lg_addr[1] == 30'h2, "R3 word order",
        {lg_addr[0][15:0], lg_addr[1][15:0]}, 32'h00010002);
    chk(lg_be[0] == 4'h3 && lg_be[1] == 4'hC, "R3 enables split",
        {24'b0, lg_be[0], lg_be[1]}, 32'h3C);
    chk(lg_a10[0] == 2'd2 && lg_a10[1] == 2'd0, "R8 split low bits",
        {28'b0, lg_a10[0], lg_a10[1]}, 32'h8);
    chk(got == {mbyte(9), mbyte(8), mbyte(7), mbyte(6)}, "R6 merged dword",
        got, 32'h49484746);
  endtask

  task automatic t_split_half;
    do_req(32'h7, 2'd1, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(ncyc == 2 && lg_be[0] == 4'h7 && lg_be[1] == 4'hE, "R3 half split",
        {24'b0, lg_be[0], lg_be[1]}, 32'h7E);
    chk(got == 32'h00004847, "R6 merged half", got, 32'h00004847);
  endtask

  task automatic t_split_write;
    do_req(32'h9, 2'd2, 1'b1, 32'hDDCCBBAA, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(ncyc == 2 && lg_be[0] == 4'h1 && lg_be[1] == 4'hE, "R3 write split",
        {24'b0, lg_be[0], lg_be[1]}, 32'h1E);
    chk(mem[2] == 32'hCCBBAA48 && mem[3] == 32'h4F4E4DDD, "R7 split store lanes",
        mem[2], 32'hCCBBAA48);
  endtask

  task automatic t_waits_and_ignore;
    waits = 3;
    @(negedge clk);
    ncyc = 0;
    req_valid = 1'b1; req_addr = 32'h2C; req_size = 2'd2; req_write = 1'b0;
    req_lock = 1'b0; req_mem = 1'b1; req_data = 1'b1;
    @(negedge clk);
    req_addr = 32'h30;  // held valid while busy: must be ignored
    repeat (2) @(negedge clk);
    chk(req_busy == 1'b1 && req_done == 1'b0, "R5 waiting while ready high",
        {30'b0, req_busy, req_done}, 32'h2);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(ncyc == 1 && lg_addr[0] == 30'hB, "R10 busy request ignored", ncyc, 1);
    chk(req_rdata == 32'h6F6E6D6C, "R5 data after waits", req_rdata, 32'h6F6E6D6C);
    waits = 0;
  endtask

  task automatic t_lock;
    do_req(32'h0, 2'd2, 1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(lg_lock[0] == 1'b1, "R9 lock at first strobe", {31'b0, lg_lock[0]}, 32'h1);
    repeat (2) @(negedge clk);
    chk(bus_lock == 1'b1, "R9 lock held between requests", {31'b0, bus_lock}, 32'h1);
    do_req(32'h2, 2'd2, 1'b1, 32'h11223344, 1'b1, 1'b1, 1'b1, 1'b1);
    chk(ncyc == 2 && lg_lock[0] && lg_lock[1], "R9 lock over split write",
        {30'b0, lg_lock[0], lg_lock[1]}, 32'h3);
    chk(bus_lock == 1'b0, "R9 lock released after final ready", {31'b0, bus_lock}, 32'h0);
    do_req(32'h4, 2'd0, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(lg_lock[0] == 1'b0, "R9 unlocked request", {31'b0, lg_lock[0]}, 32'h0);
  endtask

  initial begin
    for (int w = 0; w < 16; w++)
      for (int b = 0; b < 4; b++) mem[w][8*b +: 8] = 8'(8'h40 + 4*w + b);
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_mem = 1'b0; req_data = 1'b0; req_lock = 1'b0; req_wdata = '0;
    bus_rdy_n = 1'b1; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_aligned_read();
    t_byte_write();
    t_half_mid();
    t_split_dword();
    t_split_half();
    t_split_write();
    t_waits_and_ignore();
    t_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule